// File: doc/BRIEF.md
# SRAM Bank Address Decoder

This block turns a 32-bit bus address into a one-hot select over six SRAM banks and a word offset inside the selected bank. It sits between the bus fabric and the bank arrays and adds no cycles: the address, valid and configuration inputs reach the outputs through combinational logic only. Any address that falls outside the active map is reported as an error, so the bus side can return a bus-error response.

The map has two layouts, picked by a one-bit layout register. The split layout gives one region of instruction SRAM and one of data SRAM. The all-data layout places every bank in the data space. A separate cache-enable input takes the 4 kB bank that the cache borrows out of either map. An access to that bank while the cache is on is then treated as an unmapped address. The layout register resets to split, so instruction SRAM is usable straight after reset. A one-cycle write strobe changes the layout.

Bank sizes in bytes: bank 0 and bank 1 hold 8 kB each, bank 2 and bank 3 hold 16 kB each, bank 4 holds 12 kB and bank 5 holds 4 kB. Bank 5 is the cache bank.

Top module: `sram_bank_decoder`

## Requirements
- R1: While `rst_ni` is low, and after it is released, `mode_o` is 1 (split layout) until a write changes it.
- R2: When `mode_we_i` is high at a rising clock edge, `mode_o` takes the value of `mode_i` after that edge. While `mode_we_i` is low, `mode_o` keeps its value whatever `mode_i` does.
- R3: Split layout (`mode_o`=1). Bank 0 is at 0x20000000–0x20001FFF and bank 1 at 0x20002000–0x20003FFF. Bank 2 is at 0x10000000–0x10003FFF, bank 4 at 0x10004000–0x10006FFF and bank 5 at 0x10007000–0x10007FFF. Bank 3 is at 0x20040000–0x20043FFF.
- R4: All-data layout (`mode_o`=0). Banks 0, 1 and 2 run back to back from 0x20000000 to 0x20007FFF. Banks 3, 4 and 5 run back to back from 0x20040000 to 0x20047FFF. Nothing is mapped at 0x10000000.
- R5: For a mapped access, `offset_o` equals the address minus the base of the selected bank, divided by 4 (byte lanes dropped). With no bank selected, `offset_o` is 0.
- R6: With `cache_en_i`=1, bank 5 is never selected. An access to bank 5's range gives `err_o`=1. All other banks decode as they do with the cache off.
- R7: A valid access outside every active bank range gives `err_o`=1, `mapped_o`=0 and `bank_sel_o`=0.
- R8: With `valid_i`=0, `bank_sel_o`, `mapped_o` and `err_o` are all 0.
- R9: `bank_sel_o` has at most one bit set, with bit i meaning bank i. `mapped_o` is 1 exactly when a bit is set. For a valid access, exactly one of `mapped_o` and `err_o` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the layout register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_we_i | input | 1 | Write strobe for the layout register |
| mode_i | input | 1 | New layout value: 1 split, 0 all-data |
| cache_en_i | input | 1 | Cache owns bank 5 when high |
| valid_i | input | 1 | Access request qualifier |
| addr_i | input | 32 | Byte address of the access |
| mode_o | output | 1 | Current layout |
| bank_sel_o | output | 6 | One-hot bank select, bit i = bank i |
| offset_o | output | 12 | Word offset inside the selected bank |
| mapped_o | output | 1 | Access hits an active bank |
| err_o | output | 1 | Valid access to an unmapped address |

## Verification
The assertions are sampled at clock edges. They assume that `cache_en_i`, `valid_i` and `addr_i` are settled at each edge and that `mode_we_i` is only a one-cycle pulse. The bench keeps to this. It changes the layout strobe only at falling edges. Between edges it steps the address, and each combinational result is compared a short delay after the address changes. Addresses are swept in word steps through windows around both data sections and the instruction section, plus a few unaligned and far-off addresses, under all four combinations of layout and cache enable.

// File: rtl/sram_dec_pkg.sv
package sram_dec_pkg;

  localparam int NUM_BANKS  = 6;
  localparam int SWAP_BANK  = 2;  // moves between data and instruction space
  localparam int HI_FIRST   = 3;  // first bank of the upper data section

  typedef logic [NUM_BANKS-1:0][31:0] bank_bytes_t;

  typedef enum logic {
    MODE_DATA  = 1'b0,
    MODE_SPLIT = 1'b1
  } map_mode_e;

  function automatic logic [31:0] span(bank_bytes_t sz, int lo, int hi);
    logic [31:0] s;
    s = '0;
    for (int i = lo; i < hi; i++) s = s + sz[i];
    return s;
  endfunction

  function automatic logic [31:0] data_base(bank_bytes_t sz, logic [31:0] d0,
                                            logic [31:0] d1, int b);
    if (b < HI_FIRST) return d0 + span(sz, 0, b);
    return d1 + span(sz, HI_FIRST, b);
  endfunction

  // split layout: bank 2 then banks above bank 3 form the instruction region
  function automatic logic [31:0] split_base(bank_bytes_t sz, logic [31:0] ib,
                                             logic [31:0] d0, logic [31:0] d1,
                                             int b);
    if (b < SWAP_BANK) return d0 + span(sz, 0, b);
    if (b == SWAP_BANK) return ib;
    if (b == HI_FIRST) return d1;
    return ib + sz[SWAP_BANK] + span(sz, HI_FIRST + 1, b);
  endfunction

  function automatic int off_width(bank_bytes_t sz);
    logic [31:0] mx;
    mx = '0;
    for (int i = 0; i < NUM_BANKS; i++) if (sz[i] > mx) mx = sz[i];
    return $clog2(mx / 4);
  endfunction

endpackage

// File: rtl/sram_mode_reg.sv
module sram_mode_reg
  import sram_dec_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  logic wdata_i,
  output logic mode_o
);

  logic mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mode_q <= MODE_SPLIT;
    else if (we_i) mode_q <= wdata_i;
  end

  assign mode_o = mode_q;

endmodule

// File: rtl/sram_bank_match.sv
module sram_bank_match #(
  parameter logic [31:0] BASE_DATA  = 32'h2000_0000,
  parameter logic [31:0] BASE_SPLIT = 32'h2000_0000,
  parameter logic [31:0] BYTES      = 32'h0000_2000,
  parameter int          OFF_W      = 12
) (
  input  logic [31:0]      addr_i,
  input  logic             en_i,
  input  logic             mode_i,
  output logic             hit_o,
  output logic [OFF_W-1:0] off_o
);

  logic [31:0] base;
  logic [31:0] delta;

  assign base  = mode_i ? BASE_SPLIT : BASE_DATA;
  // unsigned wrap makes addresses below base compare large
  assign delta = addr_i - base;
  assign hit_o = en_i && (delta < BYTES);
  assign off_o = hit_o ? delta[OFF_W+1:2] : '0;

endmodule

// File: rtl/sram_hit_merge.sv
module sram_hit_merge #(
  parameter int NB    = 6,
  parameter int OFF_W = 12
) (
  input  logic                     valid_i,
  input  logic [NB-1:0]            hit_i,
  input  logic [NB-1:0][OFF_W-1:0] off_i,
  output logic [NB-1:0]            sel_o,
  output logic [OFF_W-1:0]         off_o,
  output logic                     mapped_o,
  output logic                     err_o
);

  // ranges are disjoint, so an OR of the gated offsets is exact
  always_comb begin
    off_o = '0;
    for (int i = 0; i < NB; i++) off_o = off_o | off_i[i];
  end

  assign sel_o    = hit_i;
  assign mapped_o = |hit_i;
  assign err_o    = valid_i && !mapped_o;

endmodule

// File: rtl/sram_bank_decoder.sv
module sram_bank_decoder
  import sram_dec_pkg::*;
#(
  parameter logic [31:0] INSTR_BASE = 32'h1000_0000,
  parameter logic [31:0] DATA0_BASE = 32'h2000_0000,
  parameter logic [31:0] DATA1_BASE = 32'h2004_0000,
  parameter bank_bytes_t BANK_BYTES = {32'd4096, 32'd12288, 32'd16384,
                                       32'd16384, 32'd8192, 32'd8192},
  parameter int          CACHE_BANK = 5,
  parameter int          OFF_W      = off_width(BANK_BYTES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 mode_we_i,
  input  logic                 mode_i,
  input  logic                 cache_en_i,
  input  logic                 valid_i,
  input  logic [31:0]          addr_i,
  output logic                 mode_o,
  output logic [NUM_BANKS-1:0] bank_sel_o,
  output logic [OFF_W-1:0]     offset_o,
  output logic                 mapped_o,
  output logic                 err_o
);

  logic                            mode;
  logic [NUM_BANKS-1:0]            bank_en;
  logic [NUM_BANKS-1:0]            bank_hit;
  logic [NUM_BANKS-1:0][OFF_W-1:0] bank_off;

  sram_mode_reg u_mode (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mode_we_i),
    .wdata_i (mode_i),
    .mode_o  (mode)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [31:0] BD    = data_base(BANK_BYTES, DATA0_BASE, DATA1_BASE, b);
    localparam logic [31:0] BS    = split_base(BANK_BYTES, INSTR_BASE, DATA0_BASE,
                                               DATA1_BASE, b);
    localparam logic        GATED = (b == CACHE_BANK);

    assign bank_en[b] = valid_i && !(cache_en_i && GATED);

    sram_bank_match #(
      .BASE_DATA  (BD),
      .BASE_SPLIT (BS),
      .BYTES      (BANK_BYTES[b]),
      .OFF_W      (OFF_W)
    ) u_match (
      .addr_i (addr_i),
      .en_i   (bank_en[b]),
      .mode_i (mode),
      .hit_o  (bank_hit[b]),
      .off_o  (bank_off[b])
    );
  end

  sram_hit_merge #(
    .NB    (NUM_BANKS),
    .OFF_W (OFF_W)
  ) u_merge (
    .valid_i  (valid_i),
    .hit_i    (bank_hit),
    .off_i    (bank_off),
    .sel_o    (bank_sel_o),
    .off_o    (offset_o),
    .mapped_o (mapped_o),
    .err_o    (err_o)
  );

  assign mode_o = mode;

endmodule

// File: rtl/sram_bank_decoder_chk.sv
module sram_bank_decoder_chk #(
  parameter int NB         = 6,
  parameter int OFF_W      = 12,
  parameter int CACHE_BANK = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mode_we_i,
  input logic             mode_i,
  input logic             cache_en_i,
  input logic             valid_i,
  input logic [31:0]      addr_i,
  input logic             mode_o,
  input logic [NB-1:0]    bank_sel_o,
  input logic [OFF_W-1:0] offset_o,
  input logic             mapped_o,
  input logic             err_o
);

  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_we_i |=> (mode_o == $past(mode_i)));

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_we_i |=> $stable(mode_o));

  p_no_sel_when_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_sel_o == '0) |-> (offset_o == '0));

  p_cache_bank_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cache_en_i |-> !bank_sel_o[CACHE_BANK]);

  p_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> (bank_sel_o == '0 && !mapped_o && !err_o));

  p_onehot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bank_sel_o));

  p_mapped_sel_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mapped_o == (bank_sel_o != '0));

  p_resp_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> (mapped_o != err_o));

  p_instr_hole_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !mode_o && addr_i[31:16] == 16'h1000) |-> err_o);

endmodule

bind sram_bank_decoder sram_bank_decoder_chk #(
  .NB         (sram_dec_pkg::NUM_BANKS),
  .OFF_W      (OFF_W),
  .CACHE_BANK (CACHE_BANK)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_we_i  (mode_we_i),
  .mode_i     (mode_i),
  .cache_en_i (cache_en_i),
  .valid_i    (valid_i),
  .addr_i     (addr_i),
  .mode_o     (mode_o),
  .bank_sel_o (bank_sel_o),
  .offset_o   (offset_o),
  .mapped_o   (mapped_o),
  .err_o      (err_o)
);

// File: tb/sram_bank_decoder_tb.sv
module sram_bank_decoder_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mode_we_i = 1'b0;
  logic        mode_i = 1'b0;
  logic        cache_en_i = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic        mode_o;
  logic [5:0]  bank_sel_o;
  logic [11:0] offset_o;
  logic        mapped_o;
  logic        err_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // expected map, written from the requirements
  logic [31:0] base_data  [6] = '{32'h2000_0000, 32'h2000_2000, 32'h2000_4000,
                                  32'h2004_0000, 32'h2004_4000, 32'h2004_7000};
  logic [31:0] base_split [6] = '{32'h2000_0000, 32'h2000_2000, 32'h1000_0000,
                                  32'h2004_0000, 32'h1000_4000, 32'h1000_7000};
  logic [31:0] size_b     [6] = '{32'h2000, 32'h2000, 32'h4000,
                                  32'h4000, 32'h3000, 32'h1000};

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sram_bank_decoder u_dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_we_i  (mode_we_i),
    .mode_i     (mode_i),
    .cache_en_i (cache_en_i),
    .valid_i    (valid_i),
    .addr_i     (addr_i),
    .mode_o     (mode_o),
    .bank_sel_o (bank_sel_o),
    .offset_o   (offset_o),
    .mapped_o   (mapped_o),
    .err_o      (err_o)
  );

  task automatic check_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic run_vec(input logic [31:0] a, input logic v, input logic md);
    logic [5:0]  e_sel;
    logic [11:0] e_off;
    logic        e_map;
    logic        e_err;
    logic        in_cache;
    logic [31:0] bs;
    string       tag;
    addr_i  = a;
    valid_i = v;
    #1;
    e_sel = '0;
    e_off = '0;
    in_cache = 1'b0;
    for (int b = 0; b < 6; b++) begin
      bs = md ? base_split[b] : base_data[b];
      if (a >= bs && (a - bs) < size_b[b]) begin
        if (b == 5 && cache_en_i) in_cache = 1'b1;
        else if (v) begin
          e_sel[b] = 1'b1;
          e_off    = 12'((a - bs) >> 2);
        end
      end
    end
    e_map = |e_sel;
    e_err = v && !e_map;
    if (!v)          tag = "R8";
    else if (e_map)  tag = md ? "R3" : "R4";
    else if (in_cache) tag = "R6";
    else             tag = "R7";
    checks++;
    if (bank_sel_o !== e_sel || mapped_o !== e_map || err_o !== e_err) begin
      errors++;
      $display("FAIL %s: addr %h mode %0b cache %0b sel/map/err actual %b/%b/%b expected %b/%b/%b",
               tag, a, md, cache_en_i, bank_sel_o, mapped_o, err_o, e_sel, e_map, e_err);
    end
    checks++;
    if (offset_o !== e_off) begin
      errors++;
      $display("FAIL R5: addr %h offset actual %h expected %h", a, offset_o, e_off);
    end
    checks++;
    if ($countones(bank_sel_o) > 1 || mapped_o !== (bank_sel_o != '0)) begin
      errors++;
      $display("FAIL R9: addr %h sel %b mapped %b, expected at most one bit and matching mapped",
               a, bank_sel_o, mapped_o);
    end
  endtask

  task automatic sweep(input logic md);
    logic [31:0] starts [3] = '{32'h0FFF_FF00, 32'h1FFF_FF00, 32'h2003_FF00};
    logic [31:0] extra  [8] = '{32'h0000_0000, 32'hFFFF_FFFC, 32'h2000_2003,
                                32'h1000_7001, 32'h2004_6FFF, 32'h2004_8002,
                                32'h3000_0000, 32'h2008_0000};
    for (int w = 0; w < 3; w++)
      for (int k = 0; k < 32'h8300 / 4; k++)
        run_vec(starts[w] + 32'(k * 4), 1'b1, md);
    for (int k = 0; k < 8; k++) run_vec(extra[k], 1'b1, md);
  endtask

  task automatic write_mode(input logic m);
    @(negedge clk_i);
    mode_we_i = 1'b1;
    mode_i    = m;
    @(negedge clk_i);
    mode_we_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check_bit("R1", mode_o, 1'b1);  // held in reset
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_bit("R1", mode_o, 1'b1);

    // R3: split layout, cache off then on (R6)
    cache_en_i = 1'b0;
    sweep(1'b1);
    cache_en_i = 1'b1;
    sweep(1'b1);

    // R2: load all-data layout, then toggling mode_i alone has no effect
    write_mode(1'b0);
    check_bit("R2", mode_o, 1'b0);
    mode_i = 1'b1;
    repeat (2) @(negedge clk_i);
    check_bit("R2", mode_o, 1'b0);

    // R4: all-data layout, cache off then on (R6)
    cache_en_i = 1'b0;
    sweep(1'b0);
    cache_en_i = 1'b1;
    sweep(1'b0);

    // R8: idle accesses to mapped and unmapped addresses
    cache_en_i = 1'b0;
    run_vec(32'h2000_0000, 1'b0, 1'b0);
    run_vec(32'h2004_7FFC, 1'b0, 1'b0);
    run_vec(32'h1000_0000, 1'b0, 1'b0);
    run_vec(32'h5555_5554, 1'b0, 1'b0);

    write_mode(1'b1);
    check_bit("R2", mode_o, 1'b1);
    write_mode(1'b0);
    check_bit("R2", mode_o, 1'b0);

    // R1: a second reset restores the split layout
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check_bit("R1", mode_o, 1'b1);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_bit("R1", mode_o, 1'b1);
    run_vec(32'h1000_4004, 1'b1, 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule